// File: doc/BRIEF.md
# Programmable Counter Array with PWM

This peripheral pairs one shared 16-bit time base with three independent capture/compare channels. The time base counts ticks from either the system clock or a synchronised external tick input. Either source can be slowed down by a power-of-two prescaler. Software can stop the counter and load it with any value.

Each channel owns a 16-bit compare register and one output pin, and runs in one of five modes:

- input capture on a selectable edge;
- a software timer that only raises a flag;
- a toggle-on-match output;
- a square-wave generator with a programmable half period;
- pulse-width modulation.

PWM can be edge-aligned or centre-aligned, with a width of 8, 9, 10, 11 or 16 bits. Each channel has its own output inversion. A kill input parks every PWM output at its inactive level.

Channel events and counter wrap set sticky flags, and these combine with an enable mask into one interrupt line. A simple synchronous register bus reaches all of this. Writes take effect on the clock edge. Read data is registered, so it appears one cycle after the address.

Top module: `pca_unit`

## Requirements
- R1: After reset, every register reads zero, every channel output is 0 and `irq` is 0.
- R2: Register 0 holds run (bit 0), source (bit 1, 0 = clock, 1 = rising edge of `ext_tick`) and prescale p (bits 4:2). While run is set, the counter at register 1 rises by one every 2^p source events and wraps from 0xFFFF to 0. A bus write to register 1 loads the counter, and in the same cycle it replaces any increment.
- R3: In capture mode (mode code 1), a channel input edge copies the counter into that channel's compare register and sets its flag. Mode bit 3 enables rising edges and mode bit 4 enables falling edges. An edge that is not enabled leaves both the compare register and the flag unchanged.
- R4: In software-timer mode (mode code 2), a counter step onto the compare value sets the channel flag. The channel pin stays at the level of its invert bit.
- R5: In toggle mode (mode code 3), a counter step onto the compare value inverts the channel pin and sets the channel flag.
- R6: In frequency mode (mode code 4), the pin toggles each time the counter's low byte reaches a moving target. The target then advances by compare[7:0], so with one tick per cycle the toggles come compare[7:0] cycles apart.
- R7: In edge-aligned PWM (mode code 5), the width code in mode bits 7:5 selects W: 0→8, 1→9, 2→10, 3→11, otherwise 16. The output is active while the low W counter bits are below compare[W-1:0], so each 2^W-tick period holds exactly compare active ticks.
- R8: In centre-aligned PWM (mode bit 8 set), bit W-1 of the counter selects up or down, and the low W-1 bits form a triangle. The output is active while the triangle is below compare[W-2:0], which gives 2·compare active ticks per 2^W-tick period.
- R9: In PWM mode, a new compare value takes effect only when the low W counter bits wrap to zero. A write in mid-period does not change the output.
- R10: Mode bit 9 inverts the channel pin. An inverted edge-aligned PWM output gives 2^W − compare active-high ticks per period.
- R11: While `kill` is high, every channel in PWM mode drives its invert-bit level one cycle later. Channels in other modes are unaffected.
- R12: Register 2 holds sticky flags: channel n at bit n and counter wrap at bit 3. Writing 1 clears a flag, but a new event in the same cycle keeps it set. `irq` is the registered OR of the flags masked by register 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address: 0 control, 1 counter, 2 flags, 3 interrupt enable, 4+2n mode of channel n, 5+2n compare of channel n |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for `addr` |
| ext_tick | input | 1 | External counting source (asynchronous) |
| kill | input | 1 | Forces PWM outputs to inactive level |
| ch_in | input | 3 | Capture inputs, one per channel (asynchronous) |
| ch_out | output | 3 | Registered channel outputs |
| irq | output | 1 | Interrupt request |

## Verification
Two actions can land on the same clock edge: the counter takes a bus load while it is also due to step. The bench provokes this by loading a value while the counter runs at one tick per cycle, then stopping it with the very next bus write. The readback must be exactly the loaded value plus one. That value only holds if the load replaced the pending increment and the following cycle still counted. The same priority question applies when a flag-clear write meets a new flag event; an assertion next to the flag register judges that case.

// File: rtl/pca_pkg.sv
package pca_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_CAPT   = 3'd1,
    M_SWTMR  = 3'd2,
    M_TOGGLE = 3'd3,
    M_FREQ   = 3'd4,
    M_PWM    = 3'd5
  } chmode_e;

  // Layout, msb first: inv(9) center(8) wsel(7:5) edges(4:3) mode(2:0)
  typedef struct packed {
    logic       inv;
    logic       center;
    logic [2:0] wsel;
    logic [1:0] edges;
    chmode_e    mode;
  } chcfg_t;

  localparam int CFG_W    = $bits(chcfg_t);
  localparam int REG_CTRL = 0;
  localparam int REG_CNT  = 1;
  localparam int REG_FLAG = 2;
  localparam int REG_IEN  = 3;
  localparam int REG_CH0  = 4;
endpackage

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             src_ext,
  input  logic [PRE_W-1:0] presc,
  input  logic             ext_tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             ovf
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [2:0]       ext_sync;
  logic             ext_rise;
  logic             src_evt;
  logic [DIV_W-1:0] pre;
  logic [DIV_W-1:0] lim;
  logic             tick;

  always_ff @(posedge clk) begin
    if (rst) ext_sync <= '0;
    else     ext_sync <= {ext_sync[1:0], ext_tick};
  end

  assign ext_rise = ext_sync[1] & ~ext_sync[2];
  assign src_evt  = src_ext ? ext_rise : 1'b1;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) lim[i] = (i < int'(presc));
  end

  assign tick = run & src_evt & (pre == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)  pre <= '0;
    else if (src_evt) pre <= (pre == lim) ? '0 : pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      step <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (cnt_we)    cnt <= cnt_wdata;
      else if (tick) cnt <= cnt + 1'b1;
      step <= tick & ~cnt_we;
      ovf  <= tick & ~cnt_we & (&cnt);
    end
  end

  // R2: a stopped counter holds its value
  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt));
  // R2: a bus load beats a pending increment
  a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt == $past(cnt_wdata)));
endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FREQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  chcfg_t           cfg,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             step,
  input  logic             kill,
  input  logic             ch_in,
  output logic [CNT_W-1:0] cmp_q,
  output logic             evt,
  output logic             pin
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [2:0]        in_sync;
  logic              rise, fall, cap_hit, match;
  logic [CNT_W-1:0]  shadow, eff, mask, half, lowbits, tri_v;
  logic              boundary, dir, act, tog, pre_pin, is_pwm;
  logic [FREQ_W-1:0] fpt;
  logic              f_hit;

  function automatic logic [CNT_W-1:0] width_mask(input logic [2:0] ws);
    int w;
    case (ws)
      3'd0:    w = 8;
      3'd1:    w = 9;
      3'd2:    w = 10;
      3'd3:    w = 11;
      default: w = 16;
    endcase
    if (w > CNT_W) w = CNT_W;
    for (int i = 0; i < CNT_W; i++) width_mask[i] = (i < w);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) in_sync <= '0;
    else     in_sync <= {in_sync[1:0], ch_in};
  end

  assign rise    = in_sync[1] & ~in_sync[2];
  assign fall    = ~in_sync[1] & in_sync[2];
  assign cap_hit = (cfg.mode == M_CAPT) &&
                   ((cfg.edges[0] && rise) || (cfg.edges[1] && fall));
  assign match   = step && (cnt == cmp_q);
  assign is_pwm  = (cfg.mode == M_PWM);

  always_ff @(posedge clk) begin
    if (rst)          cmp_q <= '0;
    else if (cmp_we)  cmp_q <= cmp_wdata;
    else if (cap_hit) cmp_q <= cnt;
  end

  assign evt = cap_hit ||
               (match && (cfg.mode == M_SWTMR || cfg.mode == M_TOGGLE));

  // PWM geometry
  assign mask     = width_mask(cfg.wsel);
  assign half     = mask >> 1;
  assign lowbits  = cnt & mask;
  assign boundary = step && (lowbits == '0);
  assign eff      = (!is_pwm || boundary) ? cmp_q : shadow;
  assign dir      = |(cnt & (mask ^ half));
  assign tri_v    = dir ? (~cnt & half) : (cnt & half);
  assign act      = cfg.center ? (tri_v < (eff & half)) : (lowbits < (eff & mask));

  always_ff @(posedge clk) begin
    if (rst)                       shadow <= '0;
    else if (!is_pwm || boundary)  shadow <= cmp_q;
  end

  // Toggle and frequency outputs
  assign f_hit = (cfg.mode == M_FREQ) && step && (cnt[FREQ_W-1:0] == fpt);

  always_ff @(posedge clk) begin
    if (rst) begin
      fpt <= '0;
      tog <= 1'b0;
    end else begin
      if (cfg.mode != M_FREQ) fpt <= cnt[FREQ_W-1:0] + cmp_q[FREQ_W-1:0];
      else if (f_hit)         fpt <= fpt + cmp_q[FREQ_W-1:0];
      if (f_hit || (cfg.mode == M_TOGGLE && match)) tog <= ~tog;
    end
  end

  always_comb begin
    case (cfg.mode)
      M_PWM:            pre_pin = act;
      M_TOGGLE, M_FREQ: pre_pin = tog;
      default:          pre_pin = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                 pin <= 1'b0;
    else if (is_pwm && kill) pin <= cfg.inv;
    else                     pin <= pre_pin ^ cfg.inv;
  end

  // R11: kill parks a PWM pin at its inactive level
  a_r11_kill_inactive: assert property (@(posedge clk) disable iff (rst)
    (is_pwm && kill) |=> (pin == $past(cfg.inv)));
  // R4: a software timer never drives its pin
  a_r4_timer_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == M_SWTMR) |=> (pin == $past(cfg.inv)));
  // R3: a capture stores the counter value seen at the edge
  a_r3_capture_value: assert property (@(posedge clk) disable iff (rst)
    (cap_hit && !cmp_we) |=> (cmp_q == $past(cnt)));
endmodule

// File: rtl/pca_unit.sv
module pca_unit
  import pca_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 4,
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              ext_tick,
  input  logic              kill,
  input  logic [NUM_CH-1:0] ch_in,
  output logic [NUM_CH-1:0] ch_out,
  output logic              irq
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FLG_W = NUM_CH + 1;
  localparam int CTL_W = 2 + PRE_W;

  logic [CTL_W-1:0]  ctrl;
  logic [FLG_W-1:0]  flags, ien, set_vec, clr_vec;
  logic [CNT_W-1:0]  cnt;
  logic              step, ovf;
  logic [NUM_CH-1:0] ch_evt;
  chcfg_t            cfg_q [NUM_CH];
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic              we_ctrl, we_cnt, we_flag, we_ien;

  assign we_ctrl = wr_en && (int'(addr) == REG_CTRL);
  assign we_cnt  = wr_en && (int'(addr) == REG_CNT);
  assign we_flag = wr_en && (int'(addr) == REG_FLAG);
  assign we_ien  = wr_en && (int'(addr) == REG_IEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ien  <= '0;
    end else begin
      if (we_ctrl) ctrl <= wdata[CTL_W-1:0];
      if (we_ien)  ien  <= wdata[FLG_W-1:0];
    end
  end

  pca_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_tb (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl[0]),
    .src_ext  (ctrl[1]),
    .presc    (ctrl[CTL_W-1:2]),
    .ext_tick (ext_tick),
    .cnt_we   (we_cnt),
    .cnt_wdata(wdata),
    .cnt      (cnt),
    .step     (step),
    .ovf      (ovf)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cfg_we, cmp_we;
    assign cfg_we = wr_en && (int'(addr) == REG_CH0 + 2 * g);
    assign cmp_we = wr_en && (int'(addr) == REG_CH0 + 2 * g + 1);

    always_ff @(posedge clk) begin
      if (rst)         cfg_q[g] <= '0;
      else if (cfg_we) cfg_q[g] <= chcfg_t'(wdata[CFG_W-1:0]);
    end

    pca_channel #(.CNT_W(CNT_W), .FREQ_W(FREQ_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .cfg      (cfg_q[g]),
      .cmp_we   (cmp_we),
      .cmp_wdata(wdata),
      .cnt      (cnt),
      .step     (step),
      .kill     (kill),
      .ch_in    (ch_in[g]),
      .cmp_q    (cmp_q[g]),
      .evt      (ch_evt[g]),
      .pin      (ch_out[g])
    );
  end

  assign set_vec = {ovf, ch_evt};
  assign clr_vec = we_flag ? wdata[FLG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
      irq   <= |(flags & ien);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (int'(addr))
        REG_CTRL: rdata <= CNT_W'(ctrl);
        REG_CNT:  rdata <= cnt;
        REG_FLAG: rdata <= CNT_W'(flags);
        REG_IEN:  rdata <= CNT_W'(ien);
        default: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (int'(addr) == REG_CH0 + 2 * i)     rdata <= CNT_W'(cfg_q[i]);
            if (int'(addr) == REG_CH0 + 2 * i + 1) rdata <= cmp_q[i];
          end
        end
      endcase
    end
  end

  // R12: an event in the same cycle as a clear keeps its flag set
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((flags & $past(set_vec)) == $past(set_vec)));
  // R12: interrupt follows enabled flags one cycle later
  a_r12_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(flags) & $past(ien))));
endmodule

// File: tb/tb_pca_unit.sv
module tb_pca_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_tick = 1'b0;
  logic        kill = 1'b0;
  logic [2:0]  ch_in = '0;
  logic [2:0]  ch_out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  pca_unit dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_tick(ext_tick), .kill(kill), .ch_in(ch_in),
    .ch_out(ch_out), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wdata = 16'(d); wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // driver: push the expected read value; monitor compares it
  task automatic rd_exp(input int a, input int e, input string tag);
    @(negedge clk);
    addr = 4'(a);
    @(posedge clk);
    #1;
    exp_q.push_back(16'(e));
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rdata, e);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int hc);
    hc = 0;
    repeat (n) begin
      @(negedge clk);
      hc += int'(ch_out[ch]);
    end
  endtask

  task automatic toggle_gap(input int ch, output int gap);
    logic prev;
    int   k;
    prev = ch_out[ch];
    k = 0;
    while (ch_out[ch] == prev && k < 200) begin @(negedge clk); k++; end
    prev = ch_out[ch];
    gap = 0;
    while (ch_out[ch] == prev && gap < 200) begin @(negedge clk); gap++; end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    int hc, gap;
    logic ch1_seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_exp(0, 0, "R1 ctrl");
    rd_exp(1, 0, "R1 count");
    rd_exp(2, 0, "R1 flags");
    check("R1 outputs", {ch_out, irq}, 0);

    // R2 prescale divide by 4
    wr(1, 0);
    wr(0, 9);
    idle(40);
    wr(0, 0);
    rd_exp(1, 10, "R2 prescale");

    // R2 external source
    wr(1, 0);
    wr(0, 3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) ext_tick = 1'b1; idle(3);
      ext_tick = 1'b0; idle(3);
    end
    idle(6);
    wr(0, 0);
    rd_exp(1, 5, "R2 external ticks");

    // R2 collision: load and stop on consecutive edges
    wr(0, 1);
    idle(5);
    wr(1, 16'h3000);
    wr(0, 0);
    rd_exp(1, 16'h3001, "R2 load beats increment");

    // R3 capture
    wr(1, 16'h1234);
    wr(4, 16'h0009);
    @(negedge clk) ch_in[0] = 1'b1;
    idle(6);
    rd_exp(5, 16'h1234, "R3 rising capture");
    rd_exp(2, 1, "R3 capture flag");
    wr(4, 16'h0011);
    wr(2, 16'hF);
    wr(1, 16'h5555);
    @(negedge clk) ch_in[0] = 1'b0;
    idle(6);
    rd_exp(5, 16'h5555, "R3 falling capture");
    wr(2, 16'hF);
    wr(1, 16'h7777);
    @(negedge clk) ch_in[0] = 1'b1;
    idle(6);
    rd_exp(5, 16'h5555, "R3 disabled edge ignored cmp");
    rd_exp(2, 0, "R3 disabled edge ignored flag");

    // R4 / R5 software timer and toggle
    wr(4, 0);
    wr(6, 2);  wr(7, 16'h0100);
    wr(8, 3);  wr(9, 16'h0100);
    wr(3, 2);
    wr(2, 16'hF);
    wr(1, 16'h00F0);
    wr(0, 1);
    ch1_seen = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (ch_out[1]) ch1_seen = 1'b1;
    end
    wr(0, 0);
    check("R4 timer pin stays low", ch1_seen, 0);
    rd_exp(2, 6, "R4 R5 match flags");
    check("R5 toggle pin", ch_out[2], 1);
    check("R12 irq raised", irq, 1);
    wr(2, 2);
    idle(2);
    rd_exp(2, 4, "R12 write one clears");
    check("R12 irq dropped", irq, 0);

    // R12 overflow flag
    wr(2, 16'hF);
    wr(1, 16'hFFF8);
    wr(0, 1);
    idle(20);
    wr(0, 0);
    rd_exp(2, 8, "R12 wrap flag");

    // R6 frequency output
    wr(5, 10);
    wr(4, 4);
    wr(0, 1);
    idle(30);
    toggle_gap(0, gap);
    check("R6 half period", gap, 10);
    toggle_gap(0, gap);
    check("R6 half period again", gap, 10);

    // R9 compare held until period boundary
    wr(0, 0);
    wr(4, 0);
    wr(5, 16'h0080);
    wr(4, 5);
    wr(1, 16'h0040);
    idle(3);
    check("R9 pwm active before update", ch_out[0], 1);
    wr(5, 16'h0020);
    idle(4);
    check("R9 mid-period write has no effect", ch_out[0], 1);
    wr(0, 1);
    idle(300);
    count_high(0, 256, hc);
    check("R7 R9 8-bit duty after boundary", hc, 32);

    // R7 9-bit width
    wr(4, 16'h0025);
    wr(5, 16'h0150);
    idle(600);
    count_high(0, 512, hc);
    check("R7 9-bit duty", hc, 336);

    // R10 inversion
    wr(4, 16'h0205);
    wr(5, 16'h0040);
    idle(600);
    count_high(0, 256, hc);
    check("R10 inverted duty", hc, 192);

    // R8 centre aligned
    wr(4, 16'h0105);
    wr(5, 16'h0020);
    idle(600);
    count_high(0, 256, hc);
    check("R8 centre duty", hc, 64);

    // R11 kill
    wr(8, 16'h0200);
    wr(4, 16'h0005);
    wr(5, 16'h0080);
    @(negedge clk) kill = 1'b1;
    idle(3);
    count_high(0, 256, hc);
    check("R11 killed pwm inactive", hc, 0);
    check("R11 non-pwm channel unaffected", ch_out[2], 1);
    kill = 1'b0;

    idle(4);
    report();
    $finish;
  end
endmodule